// File: doc/BRIEF.md
# Parallel Video Input Formatter

This block takes pixels from one parallel video port and turns them into a single 24-bit pixel stream. Each output beat carries a one-cycle valid strobe, a start-of-frame flag and a start-of-line flag. The port has four formats, chosen by a configuration field. Three are packed RGB words of 16, 18 or 24 bits, qualified by a data-enable input and framed by horizontal and vertical sync inputs. The fourth is an 8-bit byte stream whose timing comes from embedded four-byte codes. In that format the block decodes the codes and gathers the luma and chroma bytes that follow an active start-of-video code.

A configuration bit chooses whether the port is sampled on the rising or the falling edge of the clock. Falling-edge samples are retimed onto the rising edge, so both edges give the same latency to the output. Colour-space conversion, chroma interpolation and scaling belong to later blocks. In the byte-stream format the output word therefore carries luma and chroma rather than RGB.

The source runs freely and cannot be paused, so the output has no ready input and no back-pressure. A consumer must take every beat in the cycle in which `px_valid` is high. Between beats `px_data` keeps the last pixel.

Top module: `vin_formatter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `px_valid`, `px_sof`, `px_sol`, `px_field` and `px_data` are all zero.
- R2: Format code 0 (16-bit) takes red from bits 15..11, green from bits 10..5 and blue from bits 4..0, and ignores bits 23..16. Each component is widened to 8 bits by copying its top bits into the empty low bits. Output red sits in 23..16, green in 15..8 and blue in 7..0.
- R3: Format code 1 (18-bit) takes red from 17..12, green from 11..6 and blue from 5..0, and ignores bits 23..18. Each 6-bit component is widened by copying its top two bits below it.
- R4: Format code 2 (24-bit) passes red 23..16, green 15..8 and blue 7..0 through unchanged.
- R5: In the RGB formats, one output beat is produced for each sample taken while `vid_de` is high, and none while it is low. The beat appears two rising edges after the sampling edge.
- R6: In the RGB formats, `px_sol` marks the first beat after `vid_hs` goes from low to high. `px_sof` marks the first beat after `vid_vs` goes from low to high.
- R7: With `cfg_fall` at 0 the port is sampled on the rising clock edge. With `cfg_fall` at 1 it is sampled on the falling edge. The latency to the output is the same in both cases.
- R8: In format code 3 (byte stream), only `vid_d[7:0]` is used. `vid_hs`, `vid_vs`, `vid_de` and `vid_d[23:8]` have no effect.
- R9: In the byte stream, a code is the sequence FF, 00, 00, XY with XY bit 7 set. XY bit 6 is the field, bit 5 is vertical blanking and bit 4 is 0 for start of video and 1 for end of video. After a start-of-video code with bit 5 clear, bytes arrive as Cb, Y, Cr, Y. Each group yields two beats {Y, Cb, Cr} (Y in 23..16, Cb in 15..8, Cr in 7..0): the first when the Cr byte arrives and the second when the second Y byte arrives.
- R10: In the byte stream, `px_sol` marks the first beat after each active start-of-video code. `px_sof` marks the first beat after any code with the blanking bit set. `px_field` holds the field bit of the latest code.
- R11: In the byte stream, no beat is produced outside the active span. The active span ends at the next FF byte, and neither an end-of-video code nor a start-of-video code with the blanking bit set begins one.
- R12: `px_sof` and `px_sol` are high only together with `px_valid`. While `px_valid` is low and the format is unchanged, `px_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 2 | Input format: 0 = 16-bit, 1 = 18-bit, 2 = 24-bit, 3 = byte stream |
| cfg_fall | input | 1 | 1 = sample on the falling clock edge |
| vid_d | input | 24 | Port data |
| vid_hs | input | 1 | Horizontal sync, active high (RGB formats) |
| vid_vs | input | 1 | Vertical sync, active high (RGB formats) |
| vid_de | input | 1 | Data enable, active high (RGB formats) |
| px_valid | output | 1 | One output pixel this cycle |
| px_data | output | 24 | Output pixel |
| px_sof | output | 1 | First pixel of a frame |
| px_sol | output | 1 | First pixel of a line |
| px_field | output | 1 | Field bit of the latest embedded code |

## Verification
The bench builds the block with its default component width of 8, which gives the 24-bit port. With this width every format code is reachable, including the 16- and 18-bit unpacking with its bit copying. Both sampling edges are exercised by changing the port data between the falling and the rising edge. The byte-stream decoder is driven twice: once on clean inputs, and once with the sync pins and the upper data bits toggling at random. This covers blanking codes, two field values and back-to-back lines.

// File: rtl/vin_pkg.sv
package vin_pkg;
  typedef enum logic [1:0] {
    FMT_565  = 2'd0,
    FMT_666  = 2'd1,
    FMT_888  = 2'd2,
    FMT_BYTE = 2'd3
  } vin_fmt_e;
endpackage

// File: rtl/vin_capture.sv
module vin_capture #(
  parameter int W = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fall_sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] rise_q, fall_q, fall_rt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rise_q <= '0;
    else        rise_q <= d;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) fall_q <= '0;
    else        fall_q <= d;

  // retime the falling-edge sample so both paths reach q at the same edge
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fall_rt <= '0;
    else        fall_rt <= fall_q;

  assign q = fall_sel ? fall_rt : rise_q;
endmodule

// File: rtl/vin_rgb_unpack.sv
module vin_rgb_unpack
  import vin_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  vin_fmt_e        fmt,
  input  logic [3*CW-1:0] d,
  input  logic            hs,
  input  logic            vs,
  input  logic            de,
  output logic            o_valid,
  output logic [3*CW-1:0] o_px,
  output logic            o_sof,
  output logic            o_sol
);
  localparam int NARROW = 5;
  localparam int MID    = 6;

  // component sits in the low w bits of v; its top bits refill the low end
  function automatic logic [CW-1:0] widen(input logic [CW-1:0] v, input int w);
    logic [CW-1:0] r;
    r = '0;
    for (int k = 0; k < CW; k++) r[CW-1-k] = v[w-1-(k % w)];
    return r;
  endfunction

  logic [3*CW-1:0] unpacked;
  logic prev_hs, prev_vs, sof_pend, sol_pend;
  logic hs_rise, vs_rise;

  assign hs_rise = hs && !prev_hs;
  assign vs_rise = vs && !prev_vs;

  always_comb begin
    unpacked = d;
    case (fmt)
      FMT_565: unpacked = {widen(CW'(d[2*NARROW+MID-1 -: NARROW]), NARROW),
                           widen(CW'(d[NARROW+MID-1 -: MID]), MID),
                           widen(CW'(d[NARROW-1:0]), NARROW)};
      FMT_666: unpacked = {widen(CW'(d[3*MID-1 -: MID]), MID),
                           widen(CW'(d[2*MID-1 -: MID]), MID),
                           widen(CW'(d[MID-1:0]), MID)};
      default: unpacked = d;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hs  <= 1'b0;
      prev_vs  <= 1'b0;
      sof_pend <= 1'b0;
      sol_pend <= 1'b0;
      o_valid  <= 1'b0;
      o_px     <= '0;
      o_sof    <= 1'b0;
      o_sol    <= 1'b0;
    end else begin
      prev_hs <= hs && en;
      prev_vs <= vs && en;
      o_valid <= en && de;
      o_sof   <= 1'b0;
      o_sol   <= 1'b0;
      if (en) begin
        if (de) begin
          o_px     <= unpacked;
          o_sof    <= sof_pend || vs_rise;
          o_sol    <= sol_pend || hs_rise;
          sof_pend <= 1'b0;
          sol_pend <= 1'b0;
        end else begin
          if (vs_rise) sof_pend <= 1'b1;
          if (hs_rise) sol_pend <= 1'b1;
        end
      end else begin
        sof_pend <= 1'b0;
        sol_pend <= 1'b0;
      end
    end
  end

  // R5
  de_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> $past(en && de));
endmodule

// File: rtl/vin_byte_decode.sv
module vin_byte_decode #(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [CW-1:0]   b,
  output logic            o_valid,
  output logic [3*CW-1:0] o_px,
  output logic            o_sof,
  output logic            o_sol,
  output logic            o_field
);
  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};
  localparam logic [CW-1:0] ALL0 = '0;
  localparam int BIT_F = CW-2;
  localparam int BIT_V = CW-3;
  localparam int BIT_H = CW-4;

  logic [CW-1:0] sh1, sh2, sh3, cb, y0, cr;
  logic [1:0]    ph;
  logic          act, sof_pend, sol_pend, is_code;

  assign is_code = (sh3 == ALL1) && (sh2 == ALL0) && (sh1 == ALL0) && b[CW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh1 <= '0; sh2 <= '0; sh3 <= '0;
      cb <= '0; y0 <= '0; cr <= '0;
      ph <= '0; act <= 1'b0;
      sof_pend <= 1'b0; sol_pend <= 1'b0;
      o_valid <= 1'b0; o_px <= '0; o_sof <= 1'b0; o_sol <= 1'b0; o_field <= 1'b0;
    end else begin
      o_valid <= 1'b0;
      o_sof   <= 1'b0;
      o_sol   <= 1'b0;
      if (!en) begin
        act <= 1'b0;
        sh1 <= '0; sh2 <= '0; sh3 <= '0;
      end else begin
        sh1 <= b; sh2 <= sh1; sh3 <= sh2;
        if (is_code) begin
          act     <= !b[BIT_H] && !b[BIT_V];
          ph      <= '0;
          o_field <= b[BIT_F];
          if (b[BIT_V]) sof_pend <= 1'b1;
          if (!b[BIT_H] && !b[BIT_V]) sol_pend <= 1'b1;
        end else if (act) begin
          if (b == ALL1) begin
            act <= 1'b0;
          end else begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: cb <= b;
              2'd1: y0 <= b;
              2'd2: cr <= b;
              default: ;
            endcase
            if (ph[1]) begin
              o_valid  <= 1'b1;
              o_px     <= ph[0] ? {b, cb, cr} : {y0, cb, b};
              o_sof    <= sof_pend;
              o_sol    <= sol_pend;
              sof_pend <= 1'b0;
              sol_pend <= 1'b0;
            end
          end
        end
      end
    end
  end

  // R11
  active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> $past(act));
endmodule

// File: rtl/vin_formatter.sv
module vin_formatter
  import vin_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_fmt,
  input  logic            cfg_fall,
  input  logic [3*CW-1:0] vid_d,
  input  logic            vid_hs,
  input  logic            vid_vs,
  input  logic            vid_de,
  output logic            px_valid,
  output logic [3*CW-1:0] px_data,
  output logic            px_sof,
  output logic            px_sol,
  output logic            px_field
);
  localparam int DW = 3*CW;
  localparam int CAPW = DW + 3;

  vin_fmt_e fmt;
  logic     byte_mode;
  logic [CAPW-1:0] cap;
  logic [DW-1:0]   cd;
  logic ch, cv, ce;

  assign fmt       = vin_fmt_e'(cfg_fmt);
  assign byte_mode = (fmt == FMT_BYTE);

  vin_capture #(.W(CAPW)) u_cap (
    .clk(clk), .rst_n(rst_n), .fall_sel(cfg_fall),
    .d({vid_hs, vid_vs, vid_de, vid_d}), .q(cap)
  );
  assign {ch, cv, ce, cd} = cap;

  logic          rv, rsof, rsol;
  logic [DW-1:0] rpx;
  vin_rgb_unpack #(.CW(CW)) u_rgb (
    .clk(clk), .rst_n(rst_n), .en(!byte_mode), .fmt(fmt),
    .d(cd), .hs(ch), .vs(cv), .de(ce),
    .o_valid(rv), .o_px(rpx), .o_sof(rsof), .o_sol(rsol)
  );

  logic          bv, bsof, bsol, bfield;
  logic [DW-1:0] bpx;
  vin_byte_decode #(.CW(CW)) u_dec (
    .clk(clk), .rst_n(rst_n), .en(byte_mode), .b(cd[CW-1:0]),
    .o_valid(bv), .o_px(bpx), .o_sof(bsof), .o_sol(bsol), .o_field(bfield)
  );

  assign px_valid = byte_mode ? bv   : rv;
  assign px_data  = byte_mode ? bpx  : rpx;
  assign px_sof   = byte_mode ? bsof : rsof;
  assign px_sol   = byte_mode ? bsol : rsol;
  assign px_field = byte_mode && bfield;

  // R12
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_sof |-> px_valid);
  // R12
  sol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    px_sol |-> px_valid);
  // R12
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!px_valid && $stable(cfg_fmt)) |-> $stable(px_data));
  // R2
  red_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && fmt == FMT_565 && $stable(cfg_fmt))
      |-> px_data[2*CW+2:2*CW] == px_data[DW-1:DW-3]);
endmodule

// File: tb/tb_vin_formatter.sv
module tb_vin_formatter;
  localparam int CW = 8;
  localparam int DW = 3*CW;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_fmt;
  logic cfg_fall;
  logic [DW-1:0] vid_d;
  logic vid_hs, vid_vs, vid_de;
  logic px_valid, px_sof, px_sol, px_field;
  logic [DW-1:0] px_data;

  always #10 clk = ~clk;

  vin_formatter #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_fall(cfg_fall),
    .vid_d(vid_d), .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_de(vid_de),
    .px_valid(px_valid), .px_data(px_data), .px_sof(px_sof),
    .px_sol(px_sol), .px_field(px_field)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [DW-1:0] got_px [64];
  logic got_sof [64];
  logic got_sol [64];
  int n_got = 0;

  always @(negedge clk)
    if (rst_n && px_valid && n_got < 64) begin
      got_px[n_got]  = px_data;
      got_sof[n_got] = px_sof;
      got_sol[n_got] = px_sol;
      n_got++;
    end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic beat(input string req, input int i, input logic [DW-1:0] px,
                      input logic sof, input logic sol);
    check(req, $sformatf("beat %0d data", i), 32'(got_px[i]), 32'(px));
    check(req, $sformatf("beat %0d sof", i), 32'(got_sof[i]), 32'(sof));
    check(req, $sformatf("beat %0d sol", i), 32'(got_sol[i]), 32'(sol));
  endtask

  task automatic drv(input logic [DW-1:0] d, input logic hs, input logic vs, input logic de);
    @(posedge clk); #5;
    vid_d = d; vid_hs = hs; vid_vs = vs; vid_de = de;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv('0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic put(input logic [7:0] b, input bit junk);
    logic [31:0] r;
    r = $urandom;
    @(posedge clk); #5;
    vid_d  = junk ? {r[15:0], b} : {16'h0, b};
    vid_hs = junk & r[16];
    vid_vs = junk & r[17];
    vid_de = junk & r[18];
  endtask

  task automatic code(input logic [7:0] xy, input bit junk);
    put(8'hFF, junk); put(8'h00, junk); put(8'h00, junk); put(xy, junk);
  endtask

  task automatic t_reset();
    // R1
    check("R1", "valid", 32'(px_valid), 0);
    check("R1", "data", 32'(px_data), 0);
    check("R1", "sof", 32'(px_sof), 0);
    check("R1", "sol", 32'(px_sol), 0);
    check("R1", "field", 32'(px_field), 0);
  endtask

  task automatic t_565();
    cfg_fmt = 2'd0; idle(3); n_got = 0;
    drv('0, 0, 1, 0); drv('0, 0, 0, 0); drv('0, 1, 0, 0); drv('0, 0, 0, 0);
    drv(24'hAAFFFF, 0, 0, 1); drv(24'h558410, 0, 0, 1); drv('0, 0, 0, 0);
    drv(24'h00F800, 0, 0, 1); drv('0, 1, 0, 0); drv(24'h00001F, 0, 0, 1);
    idle(4);
    // R2 layout and widening, R6 markers
    check("R2", "beat count", n_got, 4);
    beat("R2", 0, 24'hFFFFFF, 1, 1);
    beat("R2", 1, 24'h848284, 0, 0);
    beat("R2", 2, 24'hFF0000, 0, 0);
    beat("R6", 3, 24'h0000FF, 0, 1);
  endtask

  task automatic t_666();
    cfg_fmt = 2'd1; idle(3); n_got = 0;
    drv('0, 0, 1, 0); drv('0, 1, 0, 0); drv('0, 0, 0, 0);
    drv(24'hFC0000, 0, 0, 1); drv(24'h020820, 0, 0, 1); drv(24'h03F03F, 0, 0, 1);
    drv('0, 1, 0, 0); drv(24'h00FFC0, 0, 0, 1);
    idle(4);
    // R3 layout and widening, R6 sof only once per frame
    check("R3", "beat count", n_got, 4);
    beat("R3", 0, 24'h000000, 1, 1);
    beat("R3", 1, 24'h828282, 0, 0);
    beat("R3", 2, 24'hFF00FF, 0, 0);
    beat("R6", 3, 24'h3CFF00, 0, 1);
  endtask

  task automatic t_888();
    cfg_fmt = 2'd2; idle(3); n_got = 0;
    drv('0, 1, 0, 0); drv(24'h123456, 0, 0, 1); drv(24'hEEEEEE, 0, 0, 0);
    drv(24'h789ABC, 0, 0, 1); drv(24'hDEF012, 0, 0, 1);
    idle(4);
    // R4 pass-through, R5 beats only while data enable is high
    check("R5", "beat count", n_got, 3);
    beat("R4", 0, 24'h123456, 0, 1);
    beat("R5", 1, 24'h789ABC, 0, 0);
    beat("R4", 2, 24'hDEF012, 0, 0);
  endtask

  task automatic t_edge(input logic fall);
    int start;
    int seen;
    cfg_fmt = 2'd2; cfg_fall = fall; idle(3); n_got = 0;
    drv('0, 1, 0, 0);
    @(posedge clk); #5;
    vid_d = 24'h111111; vid_hs = 0; vid_vs = 0; vid_de = 1;
    start = 0; seen = -1;
    #10 vid_d = 24'h222222;
    // R7 latency: the beat is visible after the second rising edge
    for (int i = 1; i <= 4; i++) begin
      @(posedge clk); #5;
      if (i == 1) begin vid_d = '0; vid_de = 0; end
      if (px_valid && seen < 0) seen = i;
    end
    check("R7", "latency", seen, 2);
    check("R7", "beat count", n_got, 1);
    beat("R7", 0, fall ? 24'h111111 : 24'h222222, 0, 1);
    cfg_fall = 0;
  endtask

  task automatic t_byte(input bit junk);
    string rq;
    rq = junk ? "R8" : "R9";
    cfg_fmt = 2'd3; idle(3); n_got = 0;
    code(8'hA0, junk);
    put(8'h10, junk); put(8'h80, junk); put(8'h10, junk); put(8'h80, junk);
    code(8'hB0, junk);
    code(8'h80, junk);
    put(8'h40, junk); put(8'h11, junk); put(8'hC0, junk); put(8'h22, junk);
    put(8'h50, junk); put(8'h33, junk); put(8'hD0, junk); put(8'h44, junk);
    code(8'h90, junk);
    put(8'h10, junk); put(8'h80, junk);
    code(8'h80, junk);
    put(8'h60, junk); put(8'h55, junk); put(8'hE0, junk); put(8'h66, junk);
    code(8'h90, junk);
    check("R10", "field after F=0 codes", 32'(px_field), 0);
    code(8'hC0, junk);
    put(8'h70, junk); put(8'h77, junk); put(8'hF0, junk); put(8'h88, junk);
    code(8'hD0, junk);
    idle(4);
    // R11 nothing from blanking lines or after end-of-video
    check("R11", "beat count", n_got, 8);
    beat(rq, 0, 24'h1140C0, 1, 1);
    beat(rq, 1, 24'h2240C0, 0, 0);
    beat(rq, 2, 24'h3350D0, 0, 0);
    beat(rq, 3, 24'h4450D0, 0, 0);
    beat("R10", 4, 24'h5560E0, 0, 1);
    beat(rq, 5, 24'h6660E0, 0, 0);
    beat("R10", 6, 24'h7770F0, 0, 1);
    beat(rq, 7, 24'h8870F0, 0, 0);
    check("R10", "field after F=1 codes", 32'(px_field), 1);
  endtask

  task automatic t_hold();
    logic [DW-1:0] last;
    cfg_fmt = 2'd2; idle(3);
    drv(24'h5A5A5A, 0, 0, 1); drv(24'hC3C3C3, 0, 0, 0); idle(3);
    last = px_data;
    drv(24'h0F0F0F, 1, 1, 0); idle(3);
    // R12 data held while no beat
    check("R12", "hold", 32'(px_data), 32'(last));
    check("R12", "held value", 32'(last), 32'h5A5A5A);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_fmt = 2'd2; cfg_fall = 0;
    vid_d = '0; vid_hs = 0; vid_vs = 0; vid_de = 0;
    repeat (4) @(posedge clk);
    #5 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_565();
    t_666();
    t_888();
    t_edge(1'b0);
    t_edge(1'b1);
    t_byte(1'b0);
    t_byte(1'b1);
    t_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule